// File: doc/BRIEF.md
# Pedestal-Subtracting Zero-Suppression Filter

This block takes the digitised waveform of one detector channel at a time. A waveform is a fixed run of time buckets, 511 by default. Each bucket holds a 12-bit sample and arrives on one clock, together with its channel number and its bucket index. The filter subtracts a baseline value kept per channel, with a floor at zero. It then sends the corrected samples on as (bucket index, sample) words.

In full mode every bucket goes out. In suppressed mode a bucket goes out only if it lies near a sample above the channel's threshold. The window around such a sample spans the 10 buckets before it and the 4 buckets after it. A short history of buckets is held in the block, so the leading edge of a pulse is kept even though it arrives before the sample that crosses. A single pulse on the end-of-channel flag closes each channel. That flag carries an empty indication when no word was produced for the channel.

A write port loads the baseline and threshold tables, one entry at a time, indexed by channel. Within a channel the buckets must arrive on consecutive clocks, in order from 0. At least 10 idle clocks must separate the last bucket of one channel from bucket 0 of the next. A whole channel therefore takes about 521 clocks.

Top module: `zsf_top`

## Requirements
- R1: The corrected sample is the raw sample minus the baseline entry of its channel when the raw sample is not smaller than that entry, and 0 otherwise. It never wraps.
- R2: With inFull high for a channel, one word is produced for every bucket, 0 to NUM_BUCKETS-1, carrying the corrected sample.
- R3: With inFull low, a bucket is a crossing when its corrected sample is strictly greater than the threshold entry of its channel. Bucket i is emitted exactly when a crossing lies at a bucket j with j-10 <= i <= j+4. A corrected sample equal to the threshold is not a crossing.
- R4: A window that would begin before bucket 0 starts at bucket 0. A window that would run past bucket NUM_BUCKETS-1 stops there. No word is produced for a bucket outside the channel.
- R5: When windows overlap or touch, they merge. Each bucket is emitted at most once, and within a channel the words appear in strictly increasing bucket order.
- R6: Every output word carries the 9-bit bucket index of its sample on outBucket.
- R7: outEoc is high for exactly one cycle per channel: the cycle in which the word slot for bucket NUM_BUCKETS-1 comes out. outEmpty is high in that cycle only when the channel produced no word at all, and it is then seen with outValid low.
- R8: A sample taken at clock edge n produces its word slot in the cycle after edge n+PRE+1, that is 11 cycles later with PRE=10. outValid is low in every slot that carries no word.
- R9: A table write stores cfgData into the threshold entry (cfgIsThr=1) or the baseline entry (cfgIsThr=0) of channel cfgChan. It changes no other entry.
- R10: After reset the baseline table is 0 and the threshold table is all ones. No output is high after reset or while no channel is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Table write strobe |
| cfgIsThr | input | 1 | 1 selects the threshold table, 0 selects the baseline table |
| cfgChan | input | 4 | Channel entry to write |
| cfgData | input | 12 | Value to write |
| inValid | input | 1 | A sample is present |
| inChan | input | 4 | Channel of the sample |
| inBucket | input | 9 | Bucket index of the sample |
| inSample | input | 12 | Raw sample |
| inFull | input | 1 | 1 emits all buckets, 0 applies suppression; held for the channel |
| outValid | output | 1 | An output word is present |
| outBucket | output | 9 | Bucket index of the word |
| outSample | output | 12 | Corrected sample |
| outEoc | output | 1 | End-of-channel pulse |
| outEmpty | output | 1 | With outEoc: the channel produced no word |

## Verification
Each word slot is due in the cycle after the edge n+11 for the sample taken at edge n. The bench writes its expected slot into a per-cycle table at exactly that offset, and it compares every cycle, idle cycles included, so a word that comes early, late, twice or not at all shows up as a mismatch. The end-of-channel and empty flags are expected in the slot of the last bucket, 11 cycles after it was taken. Table writes take effect for samples taken on the edge after the write. For that reason the bench writes tables only in the idle gap, at least one cycle before a channel starts.

// File: rtl/zsf_pkg.sv
package zsf_pkg;
  localparam int SAMPLE_W = 12;
  localparam int BUCKET_W = 9;

  typedef struct packed {
    logic                vld;
    logic                last;
    logic                keepAll;
    logic                over;
    logic [BUCKET_W-1:0] bucket;
    logic [SAMPLE_W-1:0] sample;
  } stage_t;

  typedef struct packed {
    logic emit;
    logic eoc;
    logic empty;
  } ctrl_t;
endpackage

// File: rtl/zsf_datapath.sv
module zsf_datapath
  import zsf_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int NUM_BUCKETS = 511,
  parameter int PRE         = 10,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic                cfgIsThr,
  input  logic [CH_W-1:0]     cfgChan,
  input  logic [SAMPLE_W-1:0] cfgData,
  input  logic                inValid,
  input  logic [CH_W-1:0]     inChan,
  input  logic [BUCKET_W-1:0] inBucket,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                inFull,
  input  ctrl_t               ctrl,
  output logic [PRE:0]        overVec,
  output stage_t              oldest,
  output logic                outValid,
  output logic [BUCKET_W-1:0] outBucket,
  output logic [SAMPLE_W-1:0] outSample,
  output logic                outEoc,
  output logic                outEmpty
);
  logic [SAMPLE_W-1:0] pedTab [NUM_CH];
  logic [SAMPLE_W-1:0] thrTab [NUM_CH];
  logic [SAMPLE_W-1:0] pedNow, thrNow, corr;
  logic                overNow;
  stage_t              pipe [PRE+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        pedTab[i] <= '0;
        thrTab[i] <= '1;
      end
    end else if (cfgWe) begin
      if (cfgIsThr) thrTab[cfgChan] <= cfgData;
      else          pedTab[cfgChan] <= cfgData;
    end
  end

  always_comb begin
    pedNow  = pedTab[inChan];
    thrNow  = thrTab[inChan];
    corr    = (inSample >= pedNow) ? (inSample - pedNow) : '0;
    overNow = inValid && (corr > thrNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pipe[0] <= '0;
    else begin
      pipe[0].vld     <= inValid;
      pipe[0].last    <= inValid && (inBucket == BUCKET_W'(NUM_BUCKETS - 1));
      pipe[0].keepAll <= inFull;
      pipe[0].over    <= overNow;
      pipe[0].bucket  <= inBucket;
      pipe[0].sample  <= corr;
    end
  end

  for (genvar k = 1; k <= PRE; k++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rstN) pipe[k] <= '0;
      else       pipe[k] <= pipe[k-1];
    end
  end

  for (genvar k = 0; k <= PRE; k++) begin : g_over
    assign overVec[k] = pipe[k].over;
  end

  assign oldest = pipe[PRE];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outBucket <= '0;
      outSample <= '0;
      outEoc    <= 1'b0;
      outEmpty  <= 1'b0;
    end else begin
      outValid  <= ctrl.emit;
      outBucket <= ctrl.emit ? oldest.bucket : '0;
      outSample <= ctrl.emit ? oldest.sample : '0;
      outEoc    <= ctrl.eoc;
      outEmpty  <= ctrl.empty;
    end
  end

  logic                haveOut;
  logic [BUCKET_W-1:0] lastOut;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveOut <= 1'b0;
      lastOut <= '0;
    end else if (outEoc) begin
      haveOut <= 1'b0;
    end else if (outValid) begin
      haveOut <= 1'b1;
      lastOut <= outBucket;
    end
  end

  // R1: the corrected value never exceeds the raw one (no wrap below zero)
  a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (pipe[0].sample <= $past(inSample)));

  // R5: buckets leave in strictly increasing order within a channel
  a_r5_increasing: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && haveOut) |-> (outBucket > lastOut));

  // R7: the empty flag only ever comes with the end marker and no word
  a_r7_empty_alone: assert property (@(posedge clk) disable iff (!rstN)
    outEmpty |-> (outEoc && !outValid));
endmodule

// File: rtl/zsf_control.sv
module zsf_control
  import zsf_pkg::*;
#(
  parameter int PRE  = 10,
  parameter int POST = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [PRE:0] overVec,
  input  stage_t       oldest,
  output ctrl_t        ctrl
);
  localparam int TAIL_W = $clog2(POST + 1);

  logic [TAIL_W-1:0] tailCnt;
  logic              seenWord;

  always_comb begin
    ctrl.emit  = oldest.vld && (oldest.keepAll || (|overVec) || (tailCnt != '0));
    ctrl.eoc   = oldest.vld && oldest.last;
    ctrl.empty = ctrl.eoc && !ctrl.emit && !seenWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tailCnt  <= '0;
      seenWord <= 1'b0;
    end else begin
      if (oldest.vld) begin
        if (oldest.last)          tailCnt <= '0;
        else if (oldest.over)     tailCnt <= TAIL_W'(POST);
        else if (tailCnt != '0)   tailCnt <= tailCnt - 1'b1;
      end
      if (ctrl.eoc)       seenWord <= 1'b0;
      else if (ctrl.emit) seenWord <= 1'b1;
    end
  end

  // R3: the bucket after a crossing always belongs to the trailing window
  a_r3_tail_follows: assert property (@(posedge clk) disable iff (!rstN)
    (oldest.vld && oldest.over && !oldest.last) |=> (!oldest.vld || ctrl.emit));

  // R3: the trailing count never exceeds the tail length
  a_r3_tail_bound: assert property (@(posedge clk) disable iff (!rstN)
    tailCnt <= TAIL_W'(POST));
endmodule

// File: rtl/zsf_top.sv
module zsf_top
  import zsf_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int NUM_BUCKETS = 511,
  parameter int PRE         = 10,
  parameter int POST        = 4,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic                cfgIsThr,
  input  logic [CH_W-1:0]     cfgChan,
  input  logic [SAMPLE_W-1:0] cfgData,
  input  logic                inValid,
  input  logic [CH_W-1:0]     inChan,
  input  logic [BUCKET_W-1:0] inBucket,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                inFull,
  output logic                outValid,
  output logic [BUCKET_W-1:0] outBucket,
  output logic [SAMPLE_W-1:0] outSample,
  output logic                outEoc,
  output logic                outEmpty
);
  ctrl_t        ctrl;
  logic [PRE:0] overVec;
  stage_t       oldest;

  zsf_datapath #(.NUM_CH(NUM_CH), .NUM_BUCKETS(NUM_BUCKETS), .PRE(PRE)) dp_i (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgIsThr(cfgIsThr), .cfgChan(cfgChan), .cfgData(cfgData),
    .inValid(inValid), .inChan(inChan), .inBucket(inBucket),
    .inSample(inSample), .inFull(inFull),
    .ctrl(ctrl), .overVec(overVec), .oldest(oldest),
    .outValid(outValid), .outBucket(outBucket), .outSample(outSample),
    .outEoc(outEoc), .outEmpty(outEmpty)
  );

  zsf_control #(.PRE(PRE), .POST(POST)) ctl_i (
    .clk(clk), .rstN(rstN),
    .overVec(overVec), .oldest(oldest), .ctrl(ctrl)
  );
endmodule

// File: tb/zsf_top_tb_top.sv
`timescale 1ns/1ps
module zsf_top_tb_top;
  localparam int NB   = 511;
  localparam int PRE  = 10;
  localparam int POST = 4;
  localparam int MAXC = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgIsThr = 0, inValid = 0, inFull = 0;
  logic [3:0]  cfgChan = 0, inChan = 0;
  logic [11:0] cfgData = 0, inSample = 0;
  logic [8:0]  inBucket = 0;
  logic outValid, outEoc, outEmpty;
  logic [8:0]  outBucket;
  logic [11:0] outSample;

  always #2.5 clk = ~clk;

  zsf_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIsThr(cfgIsThr),
    .cfgChan(cfgChan), .cfgData(cfgData), .inValid(inValid), .inChan(inChan),
    .inBucket(inBucket), .inSample(inSample), .inFull(inFull),
    .outValid(outValid), .outBucket(outBucket), .outSample(outSample),
    .outEoc(outEoc), .outEmpty(outEmpty)
  );

  int cyc = 0;
  int nChk = 0, nFail = 0;
  bit checking = 0, done = 0;
  bit expV [MAXC];
  bit expE [MAXC];
  bit expM [MAXC];
  int expB [MAXC];
  int expS [MAXC];
  string expT [MAXC];
  int mPed [16];
  int mThr [16];

  always @(posedge clk) cyc <= cyc + 1;

  // Every cycle compared; default slot tag R10 (quiet outputs), R6 covers the index
  always @(negedge clk) begin
    if (checking && cyc < MAXC) begin
      nChk++;
      if (outValid !== expV[cyc] || outEoc !== expE[cyc] || outEmpty !== expM[cyc] ||
          (expV[cyc] && (outBucket !== 9'(expB[cyc]) || outSample !== 12'(expS[cyc])))) begin
        nFail++;
        $display("FAIL %s (R8 slot, R6 index) cycle %0d: actual v=%0b b=%0d s=%0d eoc=%0b emp=%0b expected v=%0b b=%0d s=%0d eoc=%0b emp=%0b",
                 expT[cyc], cyc, outValid, outBucket, outSample, outEoc, outEmpty,
                 expV[cyc], expB[cyc], expS[cyc], expE[cyc], expM[cyc]);
      end
    end
  end

  function automatic int rawVal(int pat, int b);
    int v;
    v = 20 + (b * 13) % 31;
    if (pat == 0) v = 50 + (b * 37) % 200;
    if (pat == 1) begin
      if (b == 3 || b == 40 || b == 48 || b == 300 || b == 509) v = v + 400;
      if (b == 100) v = 210;
      if (b == 200) v = 3000;
    end
    return v;
  endfunction

  task automatic cfgWrite(input int ch, input bit isThr, input int val);
    @(negedge clk);
    cfgWe = 1; cfgIsThr = isThr; cfgChan = 4'(ch); cfgData = 12'(val);
    if (isThr) mThr[ch] = val; else mPed[ch] = val;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic runChannel(input int ch, input bit full, input int pat, input string tag);
    int corr [NB];
    bit emitF [NB];
    bit any;
    int n;
    any = 0;
    for (int b = 0; b < NB; b++) begin
      int r;
      r = rawVal(pat, b);
      corr[b]  = (r >= mPed[ch]) ? r - mPed[ch] : 0;   // R1
      emitF[b] = full;                                 // R2
    end
    if (!full)
      for (int j = 0; j < NB; j++)
        if (corr[j] > mThr[ch])                        // R3 strict compare
          for (int i = j - PRE; i <= j + POST; i++)
            if (i >= 0 && i < NB) emitF[i] = 1;        // R4 clipping, R5 merge
    for (int b = 0; b < NB; b++) any |= emitF[b];
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      inValid = 1; inChan = 4'(ch); inBucket = 9'(b);
      inSample = 12'(rawVal(pat, b)); inFull = full;
      n = cyc + 1 + PRE + 1;
      expV[n] = emitF[b]; expB[n] = b; expS[n] = corr[b];
      expT[n] = tag;
      if (b == NB - 1) begin
        expE[n] = 1; expM[n] = !any;
        expT[n] = {tag, "/R7"};
      end
    end
    @(negedge clk);
    inValid = 0;
    repeat (PRE + 2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      expV[i] = 0; expE[i] = 0; expM[i] = 0; expB[i] = 0; expS[i] = 0;
      expT[i] = "R10";
    end
    for (int i = 0; i < 16; i++) begin mPed[i] = 0; mThr[i] = 4095; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    checking = 1;
    repeat (2) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    // R10 untouched tables: nothing crosses on channel 5
    runChannel(5, 0, 1, "R10");
    // R1 saturation and R2 full mode
    cfgWrite(0, 0, 150);
    runChannel(0, 1, 0, "R1/R2");
    // R3 windows, R4 clipping at both ends, R5 merging, equal value not a crossing
    cfgWrite(1, 0, 10);
    cfgWrite(1, 1, 200);
    runChannel(1, 0, 1, "R3/R4/R5");
    // R7 empty channel
    cfgWrite(2, 1, 4000);
    runChannel(2, 0, 1, "R7");
    // R9 another channel's entries leave channel 1 unchanged
    cfgWrite(3, 0, 150);
    cfgWrite(3, 1, 350);
    runChannel(3, 0, 1, "R9");
    runChannel(1, 0, 1, "R9");
    // R2 full mode with a baseline below all samples
    runChannel(1, 1, 1, "R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule